// File: doc/BRIEF.md
# Two-Bit Stored-Program Sequencer

This block is a very small stored-program machine. A four-word program memory of two-bit words is filled while reset is held. After reset releases, the machine steps once per clock whenever the step enable is high. On each step it reads the word at the current address and turns it into a two-bit phase code. It then decodes that phase into four one-hot control lines: idle, bump, branch and stop.

A three-bit tally register counts up only while the phase is bump. The next-address logic walks forward through memory by default. In the branch phase, the word read at the following address is the jump target, and the jump is taken only while the tally's top bit is clear. When the jump is not taken, that operand word is skipped. The stop phase freezes the whole machine and raises the halted flag until the next reset.

Because there is no datapath, the block is useful mainly as a compact sequencing element or a teaching-scale controller. Its observable results are the tally value, the program address and the halted flag.

Top module: `two_bit_seq_core`

## Requirements
- R1: While `rst` is high at a clock edge, the address and the tally clear to 0, the phase becomes idle (code 00) and `halted_o` is 0.
- R2: A memory word is written from `load_word` at `load_addr` only at an edge where `rst` and `load_en` are both high. A load request made outside reset has no effect on the program that runs.
- R3: Phase codes are 00 idle, 01 bump, 10 branch and 11 stop. Exactly one decoded control line is active at any time.
- R4: In the idle and bump phases, a step moves the address to address+1, wrapping from 3 to 0.
- R5: In the bump phase, a step increments the tally by one, wrapping from 7 to 0. In every other phase the tally is unchanged.
- R6: In the branch phase with tally bit 2 equal to 0, a step loads the address with the word read at the current address.
- R7: In the branch phase with tally bit 2 equal to 1, a step moves the address to address+1 and skips the operand word.
- R8: A step taken in the branch phase always leads to the idle phase.
- R9: Once in the stop phase, the address and the tally hold and `halted_o` stays 1 until reset.
- R10: At an edge where `step_en` is low and `rst` is low, the address, the tally and the phase are unchanged.
- R11: A step taken in the idle or bump phase sets the next phase to the code of the word read at the address held before that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also opens the load window |
| step_en | input | 1 | Clock enable: one machine step per edge while high |
| load_en | input | 1 | Memory write request, honoured only during reset |
| load_addr | input | 2 | Memory word to write |
| load_word | input | 2 | Data to write |
| count_o | output | 3 | Tally register value |
| addr_o | output | 2 | Current program address |
| halted_o | output | 1 | High while in the stop phase |

## Verification
The assertions assume that `rst` is held high from time zero, so that every register has a known value before the first property is evaluated. They also assume that `step_en` and the load inputs are stable around each rising edge. The bench drives every input on the falling edge and starts with reset asserted. Random programs are loaded only inside a reset window, while stray load requests made during execution are deliberately left random so that the memory-lock rule is exercised against the bench model.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

    localparam int WORD_W = 2;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'b00,
        PH_BUMP   = 2'b01,
        PH_BRANCH = 2'b10,
        PH_STOP   = 2'b11
    } phase_e;

    typedef struct packed {
        logic idle;
        logic bump;
        logic branch;
        logic stop;
    } ctrl_t;

    function automatic phase_e word_to_phase(logic [WORD_W-1:0] w);
        phase_e p;
        case (w)
            2'b01:   p = PH_BUMP;
            2'b10:   p = PH_BRANCH;
            2'b11:   p = PH_STOP;
            default: p = PH_IDLE;
        endcase
        return p;
    endfunction

    function automatic ctrl_t phase_to_ctrl(phase_e p);
        ctrl_t c;
        c = '0;
        case (p)
            PH_BUMP:   c.bump   = 1'b1;
            PH_BRANCH: c.branch = 1'b1;
            PH_STOP:   c.stop   = 1'b1;
            default:   c.idle   = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tsm_prog_mem.sv
module tsm_prog_mem
    import tsm_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0][WORD_W-1:0] words_q;

    always_ff @(posedge clk) begin
        if (rst && wr_en) begin
            words_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = words_q[rd_addr];

    // R2
    mem_locked_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(words_q));

endmodule

// File: rtl/tsm_phase_unit.sv
module tsm_phase_unit
    import tsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic [WORD_W-1:0] fetch_word,
    output phase_e            phase_o,
    output ctrl_t             ctrl_o
);
    phase_e phase_q;
    phase_e phase_d;

    always_comb begin
        case (phase_q)
            PH_STOP:   phase_d = PH_STOP;
            PH_BRANCH: phase_d = PH_IDLE;
            default:   phase_d = word_to_phase(fetch_word);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else if (step_en) begin
            phase_q <= phase_d;
        end
    end

    assign phase_o = phase_q;
    assign ctrl_o  = phase_to_ctrl(phase_q);

    // R3
    ctrl_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot(ctrl_o));

    // R8
    branch_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && ctrl_o.branch) |=> ctrl_o.idle);

    // R9
    stop_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_o.stop |=> ctrl_o.stop);

endmodule

// File: rtl/tsm_tally.sv
module tsm_tally #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic             bump,
    output logic [CNT_W-1:0] value_o
);
    logic [CNT_W-1:0] value_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
        end else if (step_en && bump) begin
            value_q <= value_q + 1'b1;
        end
    end

    assign value_o = value_q;

    // R5
    tally_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(step_en && bump) |=> $stable(value_o));

    // R5
    tally_bump_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && bump) |=> (value_o == CNT_W'($past(value_o) + 1'b1)));

endmodule

// File: rtl/tsm_next_addr.sv
module tsm_next_addr
    import tsm_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  ctrl_t             ctrl,
    input  logic              tally_msb,
    input  logic [WORD_W-1:0] fetch_word,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_d;
    logic [ADDR_W-1:0] addr_inc;

    assign addr_inc = addr_q + 1'b1;

    always_comb begin
        addr_d = addr_q;
        if (ctrl.stop) begin
            addr_d = addr_q;
        end else if (ctrl.branch && !tally_msb) begin
            addr_d = ADDR_W'(fetch_word);
        end else begin
            addr_d = addr_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (step_en) begin
            addr_q <= addr_d;
        end
    end

    assign addr_o = addr_q;

    // R6
    jump_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && ctrl.branch && !tally_msb) |=> (addr_o == ADDR_W'($past(fetch_word))));

    // R9
    stop_addr_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.stop |=> $stable(addr_o));

    // R10
    idle_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(addr_o));

endmodule

// File: rtl/two_bit_seq_core.sv
module two_bit_seq_core
    import tsm_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [WORD_W-1:0] load_word,
    output logic [CNT_W-1:0]  count_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              halted_o
);
    logic [ADDR_W-1:0] addr_w;
    logic [WORD_W-1:0] word_w;
    logic [CNT_W-1:0]  tally_w;
    phase_e            phase_w;
    ctrl_t             ctrl_w;

    tsm_prog_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (load_en),
        .wr_addr (load_addr),
        .wr_data (load_word),
        .rd_addr (addr_w),
        .rd_data (word_w)
    );

    tsm_phase_unit u_phase (
        .clk        (clk),
        .rst        (rst),
        .step_en    (step_en),
        .fetch_word (word_w),
        .phase_o    (phase_w),
        .ctrl_o     (ctrl_w)
    );

    tsm_tally #(.CNT_W(CNT_W)) u_tally (
        .clk     (clk),
        .rst     (rst),
        .step_en (step_en),
        .bump    (ctrl_w.bump),
        .value_o (tally_w)
    );

    tsm_next_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .step_en    (step_en),
        .ctrl       (ctrl_w),
        .tally_msb  (tally_w[CNT_W-1]),
        .fetch_word (word_w),
        .addr_o     (addr_w)
    );

    assign count_o  = tally_w;
    assign addr_o   = addr_w;
    assign halted_o = (phase_w == PH_STOP);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (count_o == '0 && addr_o == '0 && !halted_o));

    // R9
    halted_hold_chk: assert property (@(posedge clk) disable iff (rst)
        halted_o |=> (halted_o && $stable(count_o)));

endmodule

// File: tb/tb_two_bit_seq_core.sv
`timescale 1ns/1ps
module tb_two_bit_seq_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_en = 1'b0;
    logic       load_en = 1'b0;
    logic [1:0] load_addr = '0;
    logic [1:0] load_word = '0;
    logic [2:0] count_o;
    logic [1:0] addr_o;
    logic       halted_o;

    int checks = 0;
    int failures = 0;

    int m_mem [4];
    int m_pc, m_cnt, m_ph;

    always #4 clk = ~clk;

    two_bit_seq_core dut (
        .clk       (clk),
        .rst       (rst),
        .step_en   (step_en),
        .load_en   (load_en),
        .load_addr (load_addr),
        .load_word (load_word),
        .count_o   (count_o),
        .addr_o    (addr_o),
        .halted_o  (halted_o)
    );

    task automatic check(string tag, int actual, int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    function automatic string step_tag(bit r, bit en, bit ld, int ph, int cnt);
        if (r)            return "R1 reset";
        if (!en)          return ld ? "R10/R2 hold" : "R10 hold";
        case (ph)
            0:       return ld ? "R4/R11/R3/R2 idle" : "R4/R11/R3 idle";
            1:       return "R5/R4/R11 bump";
            2:       return ((cnt & 4) != 0) ? "R7/R8 branch-skip" : "R6/R8 branch-take";
            default: return "R9 stop";
        endcase
    endfunction

    // Model one edge, then compare at the next falling edge.
    task automatic do_step(bit r, bit en, bit ld, int la, int lw);
        string tag;
        int w;
        rst = r; step_en = en; load_en = ld;
        load_addr = la[1:0]; load_word = lw[1:0];
        tag = step_tag(r, en, ld, m_ph, m_cnt);
        @(posedge clk);
        if (r) begin
            if (ld) m_mem[la] = lw;
            m_pc = 0; m_cnt = 0; m_ph = 0;
        end else if (en) begin
            w = m_mem[m_pc];
            case (m_ph)
                0, 1: begin
                    if (m_ph == 1) m_cnt = (m_cnt + 1) & 7;
                    m_pc = (m_pc + 1) & 3;
                    m_ph = w;
                end
                2: begin
                    m_pc = ((m_cnt & 4) != 0) ? ((m_pc + 1) & 3) : w;
                    m_ph = 0;
                end
                default: ;
            endcase
        end
        @(negedge clk);
        check({tag, " addr"}, int'(addr_o), m_pc);
        check({tag, " count"}, int'(count_o), m_cnt);
        check({tag, " halted"}, int'(halted_o), (m_ph == 3) ? 1 : 0);
    endtask

    task automatic load_prog(int w0, int w1, int w2, int w3);
        do_step(1, 0, 1, 0, w0);
        do_step(1, 0, 1, 1, w1);
        do_step(1, 0, 1, 2, w2);
        do_step(1, 0, 1, 3, w3);
        do_step(1, 0, 0, 0, 0);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_2b17;
        void'($urandom(seed));
        for (int i = 0; i < 4; i++) m_mem[i] = 0;
        m_pc = 0; m_cnt = 0; m_ph = 0;
        @(negedge clk);

        // Directed: bump, branch(target 0), operand, stop; loops until tally bit 2 sets.
        load_prog(1, 2, 0, 3);
        check("R1 reset addr", int'(addr_o), 0);
        check("R1 reset count", int'(count_o), 0);
        check("R1 reset halted", int'(halted_o), 0);
        for (int i = 0; i < 12; i++) do_step(0, 1, 0, 0, 0);
        check("R7 skip reaches addr 3", int'(addr_o), 3);
        check("R7 not yet halted", int'(halted_o), 0);
        do_step(0, 0, 1, 3, 0);
        check("R10/R2 stalled addr", int'(addr_o), 3);
        do_step(0, 1, 0, 0, 0);
        check("R3/R9 stop reached", int'(halted_o), 1);
        check("R4 wrap 3 to 0", int'(addr_o), 0);
        check("R5 tally at 4", int'(count_o), 4);
        for (int i = 0; i < 5; i++) do_step(0, 1, 1, i & 3, 1);
        check("R9 frozen addr", int'(addr_o), 0);
        check("R9 frozen count", int'(count_o), 4);

        // Directed: all bump words, tally wraps 7 to 0.
        load_prog(1, 1, 1, 1);
        for (int i = 0; i < 9; i++) do_step(0, 1, 0, 0, 0);
        check("R5 tally wrap", int'(count_o), 0);

        // Random programs with random stalls and stray loads.
        for (int p = 0; p < 60; p++) begin
            load_prog($urandom % 4, $urandom % 4, $urandom % 4, $urandom % 4);
            for (int s = 0; s < 50; s++) begin
                do_step(0, ($urandom % 8) != 0, ($urandom % 5) == 0,
                        $urandom % 4, $urandom % 4);
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule